// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog for a power-management region of a chipset. Software programs a 10-bit timeout, loads it into the counter by writing a reload command, and reads the remaining count back at any time. The counter steps down by one on every cycle in which the external tick-enable input is high and the halt bit is clear. The tick source sets the real period of one count: 0.6 s in legacy layout, 1 s in combined layout.

Expiry takes two stages. When the count is at zero and a tick arrives, the first-timeout flag sets and the counter restarts from the programmed timeout. If a second expiry arrives while that flag is still set, the second-timeout flag sets and a system reset request goes out. A no-reboot control bit can hold the request back. All flags are write-one-to-clear. A build parameter picks the legacy layout or the combined layout. The legacy layout has two 16-bit status words and a boot-status flag. The combined layout has one 32-bit status word and no boot flag.

The register port takes one access per cycle and never stalls, so it has no valid/ready handshake. Reads are combinational from the address. Word addresses: 0 reload/count, 1 timer, 2 timer upper field, 3 status 1, 4 status 2, 5 control.

Top module: `wdog2_top`

## Requirements
- R1: After reset the timeout is 4, the count reads 4, halt is set (control reads 0x1), no-reboot is clear, every status flag is clear and `sys_rst_req` is low.
- R2: A write to the timer address (1) loads bits [9:0] as the timeout only when that value is 4 or more. Values 0 to 3 are ignored. Bits [15:10] of the timer read come only from the upper-field register, which is written through address 2 bits [5:0]. A timer write never changes them.
- R3: Writing data whose bits [9:0] equal 1 to address 0 loads the counter with the timeout. Any other value has no effect. A reload wins over a tick in the same cycle. Reading address 0 returns the count in bits [9:0].
- R4: The count drops by one per tick while halt (control bit 0) is clear. It holds while halt is set or no tick arrives. Clearing halt resumes counting from the held value.
- R5: A tick at count 0 with the first-timeout flag clear sets that flag (status 1 bit 3) and reloads the counter with the timeout.
- R6: A tick at count 0 with the first-timeout flag already set sets the second-timeout flag and reloads the counter. `sys_rst_req` is high while the second-timeout flag is set and no-reboot is clear, and stays high until the flag is cleared.
- R7: If the first-timeout flag is cleared before the next expiry, that expiry sets only the first-timeout flag, so two full countdowns are again needed before a reset request.
- R8: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. If a set and a clear of the same flag fall in one cycle, the set wins.
- R9: Legacy layout: status 2 bit 1 is second-timeout and bit 2 is boot status, which is set by a `boot_fail` pulse. No-reboot is control bit 5.
- R10: Combined layout: status 1 carries first-timeout at bit 3 and second-timeout at bit 17. Status 2 reads zero and writes to it are ignored. `boot_fail` has no effect. No-reboot is control bit 4.
- R11: No-reboot reads back as written and forces `sys_rst_req` low while set. Clearing it while the second-timeout flag is set raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count-enable pulse from the tick source |
| boot_fail | input | 1 | Sets the boot-status flag (legacy layout only) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sys_rst_req | output | 1 | System reset request |

## Verification
The hardest states to reach from the ports are the second expiry and the cycle where an expiry and a software clear of the same flag meet. The bench programs a short timeout of 5, so each countdown takes six ticks. It then aligns a status-clear write, or a reload write, with the tick that finds the count at zero. Two instances, one per layout, get the same stimulus, so every flag position and the no-reboot gating are compared in both layouts from one sequence.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  localparam int WD_ADDR_W = 3;

  typedef enum logic [WD_ADDR_W-1:0] {
    WA_RELOAD = 3'd0,
    WA_TIMER  = 3'd1,
    WA_UPPER  = 3'd2,
    WA_STAT1  = 3'd3,
    WA_STAT2  = 3'd4,
    WA_CTRL   = 3'd5
  } wd_addr_e;

  typedef struct packed {
    logic first_to;
    logic second_to;
    logic boot;
  } wd_flags_t;

  typedef struct packed {
    logic first_to;
    logic second_to;
    logic boot;
  } wd_clr_t;
endpackage

// File: rtl/wdog2_counter.sv
module wdog2_counter #(
  parameter int CNT_W   = 10,
  parameter int RST_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             expire_first,
  output logic             expire_second
);
  logic step;
  logic at_zero;
  logic expire;

  assign step    = tick_en & ~halt;
  assign at_zero = (cnt == '0);
  // a reload in the same cycle pre-empts the expiry
  assign expire        = step & at_zero & ~reload;
  assign expire_first  = expire & ~armed;
  assign expire_second = expire & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CNT_W'(RST_CNT);
    end else if (reload) begin
      cnt <= load_val;
    end else if (step) begin
      if (at_zero) cnt <= load_val;
      else         cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog2_status.sv
module wdog2_status
  import wdog2_pkg::*;
#(
  parameter bit COMBINED = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_first,
  input  logic      set_second,
  input  logic      set_boot,
  input  wd_clr_t   clr,
  output wd_flags_t flags
);
  // set takes priority over a simultaneous write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n)              flags.first_to <= 1'b0;
    else if (set_first)      flags.first_to <= 1'b1;
    else if (clr.first_to)   flags.first_to <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              flags.second_to <= 1'b0;
    else if (set_second)     flags.second_to <= 1'b1;
    else if (clr.second_to)  flags.second_to <= 1'b0;
  end

  generate
    if (COMBINED) begin : g_no_boot
      logic unused_boot;
      assign unused_boot = set_boot | clr.boot;
      assign flags.boot  = 1'b0;
    end else begin : g_boot
      always_ff @(posedge clk) begin
        if (!rst_n)          flags.boot <= 1'b0;
        else if (set_boot)   flags.boot <= 1'b1;
        else if (clr.boot)   flags.boot <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/wdog2_regs.sv
module wdog2_regs
  import wdog2_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int UPPER_W  = 6,
  parameter int DATA_W   = 32,
  parameter int TMO_MIN  = 4,
  parameter int RST_TMO  = 4,
  parameter bit COMBINED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [WD_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [CNT_W-1:0]     cnt,
  input  wd_flags_t            flags,
  output logic [CNT_W-1:0]     timeout,
  output logic                 halt,
  output logic                 no_reboot,
  output logic                 reload_req,
  output wd_clr_t              clr,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam int HALT_BIT  = 0;
  localparam int NR_BIT    = COMBINED ? 4 : 5;
  localparam int TO_BIT    = 3;
  localparam int SEC1_BIT  = 17;
  localparam int SEC2_BIT  = 1;
  localparam int BOOT_BIT  = 2;
  localparam int TMR_TOP   = CNT_W + UPPER_W;

  logic [UPPER_W-1:0] upper;
  logic               hit_reload, hit_timer, hit_upper, hit_s1, hit_s2, hit_ctrl;
  logic [CNT_W-1:0]   wr_val;

  assign wr_val     = reg_wdata[CNT_W-1:0];
  assign hit_reload = reg_wr && (reg_addr == WA_RELOAD);
  assign hit_timer  = reg_wr && (reg_addr == WA_TIMER);
  assign hit_upper  = reg_wr && (reg_addr == WA_UPPER);
  assign hit_s1     = reg_wr && (reg_addr == WA_STAT1);
  assign hit_s2     = reg_wr && (reg_addr == WA_STAT2);
  assign hit_ctrl   = reg_wr && (reg_addr == WA_CTRL);

  assign reload_req = hit_reload && (wr_val == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout <= CNT_W'(RST_TMO);
    end else if (hit_timer && (wr_val >= CNT_W'(TMO_MIN))) begin
      timeout <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         upper <= '0;
    else if (hit_upper) upper <= reg_wdata[UPPER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      no_reboot <= 1'b0;
    end else if (hit_ctrl) begin
      halt      <= reg_wdata[HALT_BIT];
      no_reboot <= reg_wdata[NR_BIT];
    end
  end

  assign clr.first_to = hit_s1 & reg_wdata[TO_BIT];

  generate
    if (COMBINED) begin : g_clr_comb
      assign clr.second_to = hit_s1 & reg_wdata[SEC1_BIT];
      assign clr.boot      = 1'b0;
    end else begin : g_clr_legacy
      assign clr.second_to = hit_s2 & reg_wdata[SEC2_BIT];
      assign clr.boot      = hit_s2 & reg_wdata[BOOT_BIT];
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      WA_RELOAD: reg_rdata[CNT_W-1:0] = cnt;
      WA_TIMER:  reg_rdata[TMR_TOP-1:0] = {upper, timeout};
      WA_UPPER:  reg_rdata[UPPER_W-1:0] = upper;
      WA_STAT1: begin
        reg_rdata[TO_BIT] = flags.first_to;
        if (COMBINED) reg_rdata[SEC1_BIT] = flags.second_to;
      end
      WA_STAT2: begin
        if (!COMBINED) begin
          reg_rdata[SEC2_BIT] = flags.second_to;
          reg_rdata[BOOT_BIT] = flags.boot;
        end
      end
      WA_CTRL: begin
        reg_rdata[HALT_BIT] = halt;
        reg_rdata[NR_BIT]   = no_reboot;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int UPPER_W  = 6,
  parameter int DATA_W   = 32,
  parameter int TMO_MIN  = 4,
  parameter int RST_TMO  = 4,
  parameter bit COMBINED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 boot_fail,
  input  logic                 reg_wr,
  input  logic [WD_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 sys_rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] timeout;
  logic             halt, no_reboot, reload_req;
  logic             exp_first, exp_second;
  wd_flags_t        flags;
  wd_clr_t          clr;
  logic             first_to, second_to;

  assign first_to  = flags.first_to;
  assign second_to = flags.second_to;

  wdog2_regs #(
    .CNT_W(CNT_W), .UPPER_W(UPPER_W), .DATA_W(DATA_W),
    .TMO_MIN(TMO_MIN), .RST_TMO(RST_TMO), .COMBINED(COMBINED)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt_q), .flags(flags),
    .timeout(timeout), .halt(halt), .no_reboot(no_reboot),
    .reload_req(reload_req), .clr(clr), .reg_rdata(reg_rdata)
  );

  wdog2_counter #(.CNT_W(CNT_W), .RST_CNT(RST_TMO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .reload(reload_req), .load_val(timeout), .armed(flags.first_to),
    .cnt(cnt_q), .expire_first(exp_first), .expire_second(exp_second)
  );

  wdog2_status #(.COMBINED(COMBINED)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_first(exp_first),
    .set_second(exp_second), .set_boot(boot_fail), .clr(clr),
    .flags(flags)
  );

  assign sys_rst_req = flags.second_to & ~no_reboot;
endmodule

// File: rtl/wdog2_sva.sv
module wdog2_sva #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] timeout,
  input logic             halt,
  input logic             reload_req,
  input logic             first_to,
  input logic             second_to
);
  assert_tmo_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout >= CNT_W'(4));

  assert_reload_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (cnt_q == $past(timeout)));

  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_req) |=> $stable(cnt_q));

  assert_first_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !halt && !reload_req && cnt_q == '0) |=> first_to);

  assert_second_needs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_to) |-> ($past(first_to) && $past(tick_en) && $past(cnt_q) == '0));

  assert_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(first_to) |-> $past(reg_wr && reg_addr == 3'd3));
endmodule

bind wdog2_top wdog2_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .cnt_q(cnt_q), .timeout(timeout), .halt(halt),
  .reload_req(reload_req), .first_to(first_to), .second_to(second_to)
);

// File: tb/wdog2_top_tb.sv
module wdog2_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        boot_fail = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_l, rd_c;
  logic        rq_l, rq_c;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  wdog2_top #(.COMBINED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .boot_fail(boot_fail),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_l), .sys_rst_req(rq_l)
  );

  wdog2_top #(.COMBINED(1'b1)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .boot_fail(boot_fail),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_c), .sys_rst_req(rq_c)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [3:0]  req;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 3'd1, 4'd1, 32'h0,    32'h4},
    '{OP_RD, 3'd0, 4'd1, 32'h0,    32'h4},
    '{OP_RD, 3'd5, 4'd1, 32'h0,    32'h1},
    '{OP_RD, 3'd3, 4'd1, 32'h0,    32'h0},
    '{OP_WR, 3'd2, 4'd2, 32'h2A,   32'h0},
    '{OP_WR, 3'd1, 4'd2, 32'hFC64, 32'h0},
    '{OP_RD, 3'd1, 4'd2, 32'h0,    32'hA864},
    '{OP_WR, 3'd1, 4'd2, 32'h3,    32'h0},
    '{OP_RD, 3'd1, 4'd2, 32'h0,    32'hA864},
    '{OP_WR, 3'd1, 4'd2, 32'h0,    32'h0},
    '{OP_RD, 3'd1, 4'd2, 32'h0,    32'hA864},
    '{OP_WR, 3'd0, 4'd3, 32'h1,    32'h0},
    '{OP_RD, 3'd0, 4'd3, 32'h0,    32'd100},
    '{OP_TK, 3'd0, 4'd4, 32'd5,    32'h0},
    '{OP_RD, 3'd0, 4'd4, 32'h0,    32'd100},
    '{OP_WR, 3'd5, 4'd4, 32'h0,    32'h0},
    '{OP_TK, 3'd0, 4'd4, 32'd5,    32'h0},
    '{OP_RD, 3'd0, 4'd4, 32'h0,    32'd95},
    '{OP_WR, 3'd0, 4'd3, 32'h2,    32'h0},
    '{OP_RD, 3'd0, 4'd3, 32'h0,    32'd95},
    '{OP_WR, 3'd0, 4'd3, 32'h1,    32'h0},
    '{OP_RD, 3'd0, 4'd3, 32'h0,    32'd100},
    '{OP_WR, 3'd1, 4'd2, 32'h3FF,  32'h0},
    '{OP_RD, 3'd1, 4'd2, 32'h0,    32'hABFF}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    reg_addr = a;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset req legacy", {31'b0, rq_l}, 32'h0);
    chk("R1 reset req combined", {31'b0, rq_c}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: wr(VEC[i].addr, VEC[i].data);
        OP_TK: ticks(int'(VEC[i].data));
        default: begin
          rd(VEC[i].addr);
          chk({req_name(VEC[i].req), " table legacy"}, rd_l, VEC[i].exp);
          chk({req_name(VEC[i].req), " table combined"}, rd_c, VEC[i].exp);
        end
      endcase
    end

    // two-stage expiry with a short timeout
    do_reset();
    rd(3'd4); chk("R10 combined stat2 zero after reset", rd_c, 32'h0);
    wr(3'd1, 32'd5); wr(3'd5, 32'h0); wr(3'd0, 32'h1);
    ticks(5);
    rd(3'd0); chk("R4 count at zero", rd_l, 32'h0);
    rd(3'd3); chk("R5 no flag before expiry", rd_l, 32'h0);
    ticks(1);
    rd(3'd3); chk("R5 first flag legacy", rd_l, 32'h8);
    chk("R5 first flag combined", rd_c, 32'h8);
    rd(3'd0); chk("R5 reloaded count", rd_l, 32'd5);
    chk("R5 no reset req", {31'b0, rq_l}, 32'h0);
    ticks(5);
    rd(3'd4); chk("R6 no second flag yet", rd_l, 32'h0);
    ticks(1);
    rd(3'd4); chk("R9 legacy second flag at stat2 bit1", rd_l, 32'h2);
    rd(3'd3); chk("R10 combined stat1 bits 3 and 17", rd_c, 32'h20008);
    chk("R6 reset req legacy", {31'b0, rq_l}, 32'h1);
    chk("R6 reset req combined", {31'b0, rq_c}, 32'h1);
    ticks(3);
    chk("R6 reset req held", {31'b0, rq_l}, 32'h1);
    wr(3'd3, 32'h20008); wr(3'd4, 32'h6);
    chk("R6 reset req drops on clear", {31'b0, rq_l}, 32'h0);
    chk("R8 combined clears bit17", {31'b0, rq_c}, 32'h0);

    // service between expiries restarts the two-stage count
    wr(3'd0, 32'h1);
    ticks(6);
    wr(3'd3, 32'h8);
    rd(3'd3); chk("R8 first flag cleared", rd_l, 32'h0);
    ticks(6);
    rd(3'd3); chk("R7 only first flag again", rd_l, 32'h8);
    rd(3'd4); chk("R7 no second flag", rd_l, 32'h0);
    chk("R7 no reset req", {31'b0, rq_l}, 32'h0);
    ticks(6);
    chk("R7 reset req after two expiries", {31'b0, rq_l}, 32'h1);

    // no-reboot gating per layout
    wr(3'd5, 32'h20);
    rd(3'd5); chk("R11 legacy noreboot readback", rd_l, 32'h20);
    chk("R10 combined ignores bit5", rd_c, 32'h0);
    chk("R11 legacy req blocked", {31'b0, rq_l}, 32'h0);
    chk("R11 combined req still high", {31'b0, rq_c}, 32'h1);
    wr(3'd5, 32'h10);
    rd(3'd5); chk("R10 combined noreboot bit4", rd_c, 32'h10);
    chk("R11 legacy req returns", {31'b0, rq_l}, 32'h1);
    chk("R11 combined req blocked", {31'b0, rq_c}, 32'h0);

    // boot status and layout-specific clears
    @(negedge clk); boot_fail = 1'b1;
    @(negedge clk); boot_fail = 1'b0;
    rd(3'd4); chk("R9 boot status set", rd_l, 32'h6);
    chk("R10 combined stat2 still zero", rd_c, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd3); chk("R8 zero write legacy", rd_l, 32'h8);
    chk("R8 zero write combined", rd_c, 32'h20008);
    wr(3'd4, 32'h4);
    rd(3'd4); chk("R9 boot cleared alone", rd_l, 32'h2);
    wr(3'd4, 32'h2);
    rd(3'd4); chk("R9 second cleared via stat2", rd_l, 32'h0);
    rd(3'd3); chk("R10 stat2 write ignored in combined", rd_c, 32'h20008);
    wr(3'd3, 32'h20008); wr(3'd5, 32'h0);
    rd(3'd3); chk("R8 combined fully cleared", rd_c, 32'h0);

    // set vs clear in one cycle
    wr(3'd0, 32'h1);
    ticks(5);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h8;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(3'd3); chk("R8 set wins legacy", rd_l, 32'h8);
    chk("R8 set wins combined", rd_c, 32'h8);

    // reload vs tick in one cycle
    ticks(2);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(3'd0); chk("R3 reload beats tick", rd_l, 32'd5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule